// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block sits in the decode stage of a five-stage in-order pipeline. For each of the two source operands of the instruction in decode, it picks the value to use. The value comes either from the register-file read port or from a newer result that is still moving through a later stage and has not yet been written back. With this selection in place, an instruction that directly follows one that writes a register can proceed without waiting.

Five in-flight results are candidates: the execute-stage ALU output, the memory stage's ALU result and loaded value, and the write-back stage's ALU result and loaded value. When more than one candidate targets the same register, the result from the youngest-producing stage (the one nearest decode) wins, so the program still sees the most recent write. Operand A also has an override: for a call or a jump, it carries the incremented PC instead of any register value.

The block is purely combinational. Register file, ALU and stall generation sit elsewhere. The execute destination ID is expected to be already condition-adjusted, so a conditional move that does not fire shows up as the no-register ID.

Top module: `opnd_bypass`

## Requirements
- R1: When `dec_class` equals `CALL_CODE` (default 4'h8) or `JUMP_CODE` (default 4'h7), `opnd_a` equals `dec_next_pc`, whatever the register IDs are.
- R2: A source ID that equals `ex_dst` selects `ex_val`, ahead of every other source.
- R3: Without an execute match, a source ID that equals `mem_dst_ld` selects `mem_val_ld`.
- R4: Without the matches above, a source ID that equals `mem_dst_alu` selects `mem_val_alu`.
- R5: Without the matches above, a source ID that equals `wb_dst_ld` selects `wb_val_ld`.
- R6: Without the matches above, a source ID that equals `wb_dst_alu` selects `wb_val_alu`.
- R7: When no in-flight destination matches, the operand equals its register-file read data (`rf_data_a` or `rf_data_b`).
- R8: The all-ones register ID (4'hF at default width) means "no register". A source or destination carrying it never produces a match, so such an operand takes the register-file data unless R1 applies.
- R9: `opnd_b` uses the same chain as R2 to R7 and never takes `dec_next_pc`, even for call or jump classes.
- R10: The two operands are resolved independently: each may win from a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | RID_W | Source register ID for operand A |
| dec_src_b | input | RID_W | Source register ID for operand B |
| dec_class | input | CLASS_W | Instruction class code of the decode instruction |
| dec_next_pc | input | DATA_W | Incremented PC of the decode instruction |
| rf_data_a | input | DATA_W | Register-file read data for operand A |
| rf_data_b | input | DATA_W | Register-file read data for operand B |
| ex_dst | input | RID_W | Condition-adjusted destination of the execute ALU result |
| ex_val | input | DATA_W | Execute ALU result |
| mem_dst_ld | input | RID_W | Memory-stage load destination |
| mem_val_ld | input | DATA_W | Memory-stage loaded value |
| mem_dst_alu | input | RID_W | Memory-stage ALU destination |
| mem_val_alu | input | DATA_W | Memory-stage ALU result |
| wb_dst_ld | input | RID_W | Write-back load destination |
| wb_val_ld | input | DATA_W | Write-back loaded value |
| wb_dst_alu | input | RID_W | Write-back ALU destination |
| wb_val_alu | input | DATA_W | Write-back ALU result |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |

## Verification
The bench builds the block with 2-bit register IDs and 8-bit values. With IDs that narrow, it can sweep every combination of both source IDs and all five destination IDs, including the all-ones "no register" code, for a neutral class, the call class and the jump class. Each candidate carries a distinct constant value, so every priority tie, every lone match and every case where nothing matches is reached, for both operands together. The expected operand is rebuilt in the bench by layering sources from oldest to youngest.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;

  // Number of in-flight candidates; index 0 is the youngest (highest priority).
  localparam int unsigned NSRC = 5;

  localparam int unsigned IDX_EX      = 0;
  localparam int unsigned IDX_MEM_LD  = 1;
  localparam int unsigned IDX_MEM_ALU = 2;
  localparam int unsigned IDX_WB_LD   = 3;
  localparam int unsigned IDX_WB_ALU  = 4;

  typedef logic [NSRC-1:0] hit_vec_t;

  // Keep only the lowest set bit: lowest index means highest priority.
  function automatic hit_vec_t lowest_hit(input hit_vec_t hit);
    hit_vec_t neg;
    neg = ~hit + hit_vec_t'(1);
    return hit & neg;
  endfunction

  // True when the class code is one that carries the incremented PC in operand A.
  function automatic logic takes_pc(input logic [7:0] cls, input logic [7:0] call_c,
                                    input logic [7:0] jump_c);
    return (cls == call_c) || (cls == jump_c);
  endfunction

endpackage

// File: rtl/opnd_bypass_match.sv
module opnd_bypass_match
  import opnd_bypass_pkg::*;
#(
  parameter int unsigned RID_W = 4
) (
  input  logic [RID_W-1:0]           src_id,
  input  logic [NSRC-1:0][RID_W-1:0] dst_id,
  output hit_vec_t                   hit
);

  localparam logic [RID_W-1:0] NO_REG = '1;

  logic src_real;
  assign src_real = (src_id != NO_REG);

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign hit[i] = src_real && (dst_id[i] == src_id);
  end

  // The no-register ID never produces a hit on any lane.
  always_comb begin
    if (!$isunknown(src_id) && !$isunknown(dst_id)) begin
      assert_noreg_silent_R8: assert ((src_id != NO_REG) || (hit == '0))
        else $error("no-register source produced a bypass hit");
    end
  end

endmodule

// File: rtl/opnd_bypass_pick.sv
module opnd_bypass_pick
  import opnd_bypass_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  hit_vec_t                    hit,
  input  logic [NSRC-1:0][DATA_W-1:0] cand,
  input  logic [DATA_W-1:0]           fallback,
  output logic [DATA_W-1:0]           picked
);

  hit_vec_t grant;
  logic     any_hit;

  assign grant   = lowest_hit(hit);
  assign any_hit = |hit;

  always_comb begin
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NSRC; i++) begin
      acc = acc | (cand[i] & {DATA_W{grant[i]}});
    end
    picked = any_hit ? acc : fallback;
  end

  always_comb begin
    if (!$isunknown(hit)) begin
      assert_single_grant_R2: assert ($onehot0(grant) && (any_hit == (grant != '0)))
        else $error("bypass grant not one-hot");
      assert_youngest_wins_R3: assert (!(hit[IDX_EX] == 1'b0 && hit[IDX_MEM_LD]) ||
                                       grant[IDX_MEM_LD])
        else $error("memory load hit not granted");
    end
  end

endmodule

// File: rtl/opnd_bypass_lane.sv
module opnd_bypass_lane
  import opnd_bypass_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned RID_W  = 4
) (
  input  logic [RID_W-1:0]            src_id,
  input  logic [NSRC-1:0][RID_W-1:0]  dst_id,
  input  logic [NSRC-1:0][DATA_W-1:0] cand,
  input  logic [DATA_W-1:0]           rf_data,
  input  logic                        pc_take,
  input  logic [DATA_W-1:0]           pc_val,
  output logic [DATA_W-1:0]           opnd
);

  hit_vec_t          hit;
  logic [DATA_W-1:0] fwd_val;

  opnd_bypass_match #(.RID_W(RID_W)) u_match (
    .src_id (src_id),
    .dst_id (dst_id),
    .hit    (hit)
  );

  opnd_bypass_pick #(.DATA_W(DATA_W)) u_pick (
    .hit      (hit),
    .cand     (cand),
    .fallback (rf_data),
    .picked   (fwd_val)
  );

  assign opnd = pc_take ? pc_val : fwd_val;

  always_comb begin
    if (!$isunknown({hit, pc_take})) begin
      assert_rf_default_R7: assert (pc_take || (hit != '0) || (opnd == rf_data))
        else $error("unmatched operand did not use register file");
      assert_ex_first_R2: assert (pc_take || !hit[IDX_EX] || (opnd == cand[IDX_EX]))
        else $error("execute match did not win");
    end
  end

endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
  import opnd_bypass_pkg::*;
#(
  parameter int unsigned     DATA_W    = 64,
  parameter int unsigned     RID_W     = 4,
  parameter int unsigned     CLASS_W   = 4,
  parameter logic [CLASS_W-1:0] CALL_CODE = CLASS_W'(8),
  parameter logic [CLASS_W-1:0] JUMP_CODE = CLASS_W'(7)
) (
  input  logic [RID_W-1:0]   dec_src_a,
  input  logic [RID_W-1:0]   dec_src_b,
  input  logic [CLASS_W-1:0] dec_class,
  input  logic [DATA_W-1:0]  dec_next_pc,
  input  logic [DATA_W-1:0]  rf_data_a,
  input  logic [DATA_W-1:0]  rf_data_b,
  input  logic [RID_W-1:0]   ex_dst,
  input  logic [DATA_W-1:0]  ex_val,
  input  logic [RID_W-1:0]   mem_dst_ld,
  input  logic [DATA_W-1:0]  mem_val_ld,
  input  logic [RID_W-1:0]   mem_dst_alu,
  input  logic [DATA_W-1:0]  mem_val_alu,
  input  logic [RID_W-1:0]   wb_dst_ld,
  input  logic [DATA_W-1:0]  wb_val_ld,
  input  logic [RID_W-1:0]   wb_dst_alu,
  input  logic [DATA_W-1:0]  wb_val_alu,
  output logic [DATA_W-1:0]  opnd_a,
  output logic [DATA_W-1:0]  opnd_b
);

  localparam int unsigned NLANE = 2;

  logic [NSRC-1:0][RID_W-1:0]  dst_all;
  logic [NSRC-1:0][DATA_W-1:0] val_all;
  logic [NLANE-1:0][RID_W-1:0]  src_all;
  logic [NLANE-1:0][DATA_W-1:0] rf_all;
  logic [NLANE-1:0][DATA_W-1:0] out_all;
  logic                        ctl_flow;

  // Candidate order is the priority order: youngest stage first.
  assign dst_all[IDX_EX]      = ex_dst;
  assign dst_all[IDX_MEM_LD]  = mem_dst_ld;
  assign dst_all[IDX_MEM_ALU] = mem_dst_alu;
  assign dst_all[IDX_WB_LD]   = wb_dst_ld;
  assign dst_all[IDX_WB_ALU]  = wb_dst_alu;

  assign val_all[IDX_EX]      = ex_val;
  assign val_all[IDX_MEM_LD]  = mem_val_ld;
  assign val_all[IDX_MEM_ALU] = mem_val_alu;
  assign val_all[IDX_WB_LD]   = wb_val_ld;
  assign val_all[IDX_WB_ALU]  = wb_val_alu;

  assign src_all[0] = dec_src_a;
  assign src_all[1] = dec_src_b;
  assign rf_all[0]  = rf_data_a;
  assign rf_all[1]  = rf_data_b;

  assign ctl_flow = takes_pc(8'(dec_class), 8'(CALL_CODE), 8'(JUMP_CODE));

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    // Only lane 0 (operand A) honours the incremented-PC override.
    localparam bit PC_OVR = (g == 0);
    logic lane_pc;
    assign lane_pc = PC_OVR ? ctl_flow : 1'b0;

    opnd_bypass_lane #(.DATA_W(DATA_W), .RID_W(RID_W)) u_lane (
      .src_id  (src_all[g]),
      .dst_id  (dst_all),
      .cand    (val_all),
      .rf_data (rf_all[g]),
      .pc_take (lane_pc),
      .pc_val  (dec_next_pc),
      .opnd    (out_all[g])
    );
  end

  assign opnd_a = out_all[0];
  assign opnd_b = out_all[1];

  localparam logic [RID_W-1:0] NO_REG = '1;

  always_comb begin
    if (!$isunknown({dec_class, dec_src_a, dec_src_b, dst_all})) begin
      assert_pc_override_R1: assert (!((dec_class == CALL_CODE) || (dec_class == JUMP_CODE)) ||
                                     (opnd_a == dec_next_pc))
        else $error("call/jump operand A is not the incremented PC");
      assert_b_no_pc_R9: assert ((dec_src_b == NO_REG) == 1'b0 || (opnd_b == rf_data_b))
        else $error("operand B with no register did not use register file");
      assert_wb_alu_last_R6: assert (ctl_flow || dec_src_a == NO_REG ||
                                     dec_src_a != wb_dst_alu ||
                                     dec_src_a == ex_dst || dec_src_a == mem_dst_ld ||
                                     dec_src_a == mem_dst_alu || dec_src_a == wb_dst_ld ||
                                     opnd_a == wb_val_alu)
        else $error("lone write-back ALU match not taken");
    end
  end

endmodule

// File: tb/opnd_bypass_test.sv
module opnd_bypass_test;

  localparam int unsigned DW = 8;
  localparam int unsigned RW = 2;
  localparam int unsigned CW = 4;
  localparam logic [RW-1:0] NOREG = 2'b11;

  localparam logic [DW-1:0] V_EX = 8'hA1, V_ML = 8'hB2, V_MA = 8'hC3,
                            V_WL = 8'hD4, V_WA = 8'hE5, V_RA = 8'h15,
                            V_RB = 8'h26, V_PC = 8'h7F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [RW-1:0] sa, sb, de, dml, dma, dwl, dwa;
  logic [CW-1:0] cls;
  logic [DW-1:0] oa, ob;

  int checks = 0;
  int errors = 0;

  opnd_bypass #(.DATA_W(DW), .RID_W(RW), .CLASS_W(CW)) uut (
    .dec_src_a(sa), .dec_src_b(sb), .dec_class(cls), .dec_next_pc(V_PC),
    .rf_data_a(V_RA), .rf_data_b(V_RB),
    .ex_dst(de), .ex_val(V_EX),
    .mem_dst_ld(dml), .mem_val_ld(V_ML),
    .mem_dst_alu(dma), .mem_val_alu(V_MA),
    .wb_dst_ld(dwl), .wb_val_ld(V_WL),
    .wb_dst_alu(dwa), .wb_val_alu(V_WA),
    .opnd_a(oa), .opnd_b(ob)
  );

  // Layer sources oldest first so the youngest match overwrites.
  function automatic logic [DW-1:0] model(input logic [RW-1:0] s, input logic [DW-1:0] rf,
                                          input bit lane_a, output string tag);
    logic [DW-1:0] r;
    if (lane_a && (cls == 4'h8 || cls == 4'h7)) begin
      tag = "R1";
      return V_PC;
    end
    r = rf;
    tag = (s == NOREG) ? "R8" : "R7";
    if (s != NOREG) begin
      if (dwa == s) begin r = V_WA; tag = "R6"; end
      if (dwl == s) begin r = V_WL; tag = "R5"; end
      if (dma == s) begin r = V_MA; tag = "R4"; end
      if (dml == s) begin r = V_ML; tag = "R3"; end
      if (de  == s) begin r = V_EX; tag = "R2"; end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors < 20)
        $display("FAIL %s: got %h expected %h (sa=%0d sb=%0d cls=%h dst=%0d %0d %0d %0d %0d)",
                 tag, act, exp, sa, sb, cls, de, dml, dma, dwl, dwa);
    end
  endtask

  task automatic drive(input logic [RW-1:0] a, b, e, ml, ma, wl, wa, input logic [CW-1:0] c);
    @(posedge clk);
    sa = a; sb = b; de = e; dml = ml; dma = ma; dwl = wl; dwa = wa; cls = c;
    @(negedge clk);
  endtask

  initial begin
    sa = NOREG; sb = NOREG; de = NOREG; dml = NOREG; dma = NOREG;
    dwl = NOREG; dwa = NOREG; cls = 4'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state: nothing in flight, operands from register file (R7, R8).
    check("R7", oa, V_RA);
    check("R8", ob, V_RB);

    // Directed: independent lanes (R10), A hits execute, B hits write-back ALU.
    drive(2'd0, 2'd1, 2'd0, 2'd3, 2'd3, 2'd3, 2'd1, 4'h0);
    check("R10", oa, V_EX);
    check("R10", ob, V_WA);
    // Directed: call with operand B matching execute (R9 and R1).
    drive(2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 4'h8);
    check("R1", oa, V_PC);
    check("R9", ob, V_EX);
    // Directed: all-ones destinations with all-ones source (R8).
    drive(NOREG, 2'd0, NOREG, NOREG, NOREG, NOREG, NOREG, 4'h0);
    check("R8", oa, V_RA);
    check("R7", ob, V_RB);

    // Sweep every ID combination for a neutral class, jump and call.
    for (int ci = 0; ci < 3; ci++) begin
      for (int k = 0; k < (1 << (7 * RW)); k++) begin
        string ta, tb;
        logic [DW-1:0] ea, eb;
        logic [CW-1:0] cc;
        cc = (ci == 0) ? 4'h3 : (ci == 1) ? 4'h7 : 4'h8;
        drive(RW'(k), RW'(k >> 2), RW'(k >> 4), RW'(k >> 6), RW'(k >> 8),
              RW'(k >> 10), RW'(k >> 12), cc);
        ea = model(sa, V_RA, 1'b1, ta);
        eb = model(sb, V_RB, 1'b0, tb);
        check(ta, oa, ea);
        check((ci != 0) ? "R9" : tb, ob, eb);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule